// File: doc/BRIEF.md
# Memory Bus Module Select Decoder

This block sits between a processor's memory bus and the memories hanging off it. For every memory cycle request it decides which single memory sees the cycle: a small fast memory, or one of up to sixteen core modules of 16K words each. A request that asks for fast memory, and whose address lies in the small fast window, is offered to fast memory first. If fast memory is absent or does not answer, the same request is decoded as an ordinary core access.

The core module number is the top four bits of the 18-bit word address, so module n holds addresses n·16384 up to n·16384+16383. A module is enabled only if its present flag is set. If the chosen core module is absent or does not acknowledge, the block raises a nonexistent-memory flag for one cycle. The caller offers a request for one cycle while the decoder is idle and then watches the enables and the flag.

Top module: `memSelDecoder`

## Requirements
- R1: After reset, `fastEn`, every bit of `coreEn` and `nxmFlag` are 0.
- R2: A request taken with `reqFastSel`=1, `reqAddr` < 16 and `fastPresent`=1 raises `fastEn` for exactly one cycle, in the cycle after the request edge, with `coreEn` all 0.
- R3: If `fastAck` is 1 while `fastEn` is 1, the cycle ends there: no `coreEn` bit rises and `nxmFlag` stays 0.
- R4: If `fastAck` is 0 while `fastEn` is 1, the next cycle decodes the request as a core access, raising the core enable as in R5.
- R5: The core module number is `reqAddr[17:14]`. In the core cycle exactly bit n of `coreEn` is 1 for module n when `corePresent[n]`=1, and `fastEn` is 0.
- R6: A request with `reqFastSel`=0, with `reqAddr` >= 16, or with `fastPresent`=0 skips fast memory: the core cycle is the cycle right after the request edge.
- R7: If the addressed core module has `corePresent`=0, no enable rises and `nxmFlag` is 1 in the cycle after the core cycle.
- R8: If the addressed module is present but `coreAck` for it is 0 during the core cycle, `nxmFlag` is 1 in the next cycle.
- R9: `nxmFlag` is high for one cycle only; when the addressed present module acknowledges, `nxmFlag` stays 0.
- R10: `reqValid` and the request inputs are ignored while a cycle is in progress; the outcome follows the request that started the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Memory cycle request, taken when idle |
| reqFastSel | input | 1 | Request asks for fast memory |
| reqAddr | input | 18 | Word address of the request |
| fastPresent | input | 1 | Fast memory is attached |
| fastAck | input | 1 | Fast memory accepts the offered cycle |
| corePresent | input | 16 | Per-module present flags |
| coreAck | input | 16 | Per-module acknowledge |
| fastEn | output | 1 | Fast memory enable |
| coreEn | output | 16 | One-hot core module enables |
| nxmFlag | output | 1 | Nonexistent-memory pulse |

## Verification
A wrong latched module number shows at once as the wrong `coreEn` bit in the core cycle, one or two cycles after the request. A wrong sequencer state shows as an enable that lasts two cycles, a core enable after a fast acknowledge, or an `nxmFlag` pulse that is missing, doubled or early. Every such fault is visible within three cycles of the request. The sweep covers all sixteen module numbers against mixes of present and acknowledge flags, plus the fast-window edge at addresses 15 and 16.

// File: rtl/memSelPkg.sv
package memSelPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FAST = 2'd1,
    ST_CORE = 2'd2
  } selState_t;

  typedef struct packed {
    logic load;
    logic driveFast;
    logic driveCore;
    logic flagNxm;
  } ctlStrobe_t;
endpackage

// File: rtl/memSelDatapath.sv
module memSelDatapath
  import memSelPkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int MOD_BITS   = 4,
  parameter int FAST_WORDS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic                       reqFastSel,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       fastPresent,
  input  logic                       fastAck,
  input  logic [(1<<MOD_BITS)-1:0]   corePresent,
  input  logic [(1<<MOD_BITS)-1:0]   coreAck,
  output logic                       fastRoute,
  output logic                       fastHit,
  output logic                       coreHit,
  output logic                       fastEn,
  output logic [(1<<MOD_BITS)-1:0]   coreEn,
  output logic                       nxmFlag
);
  localparam int NUM_MOD = 1 << MOD_BITS;
  localparam logic [ADDR_W-1:0] FAST_LIMIT = ADDR_W'(FAST_WORDS);

  logic [MOD_BITS-1:0] modQ;
  logic                nxmQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ <= '0;
      nxmQ <= 1'b0;
    end else begin
      if (strobe.load) modQ <= reqAddr[ADDR_W-1 -: MOD_BITS];
      nxmQ <= strobe.flagNxm;
    end
  end

  // Fast window check uses the live request, valid only in the idle cycle
  assign fastRoute = reqFastSel && (reqAddr < FAST_LIMIT) && fastPresent;

  assign fastEn  = strobe.driveFast;
  assign fastHit = fastEn && fastAck;

  generate
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
      assign coreEn[i] = strobe.driveCore && (modQ == MOD_BITS'(i)) && corePresent[i];
    end
  endgenerate

  assign coreHit = |(coreEn & coreAck);
  assign nxmFlag = nxmQ;
endmodule

// File: rtl/memSelControl.sv
module memSelControl
  import memSelPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       fastRoute,
  input  logic       fastHit,
  input  logic       coreHit,
  output ctlStrobe_t strobe
);
  selState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNext   = fastRoute ? ST_FAST : ST_CORE;
        end
      end
      ST_FAST: begin
        strobe.driveFast = 1'b1;
        stateNext        = fastHit ? ST_IDLE : ST_CORE;
      end
      ST_CORE: begin
        strobe.driveCore = 1'b1;
        strobe.flagNxm   = !coreHit;
        stateNext        = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/memSelDecoder.sv
module memSelDecoder
  import memSelPkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int MOD_BITS   = 4,
  parameter int FAST_WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqFastSel,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     fastPresent,
  input  logic                     fastAck,
  input  logic [(1<<MOD_BITS)-1:0] corePresent,
  input  logic [(1<<MOD_BITS)-1:0] coreAck,
  output logic                     fastEn,
  output logic [(1<<MOD_BITS)-1:0] coreEn,
  output logic                     nxmFlag
);
  ctlStrobe_t strobe;
  logic fastRoute, fastHit, coreHit;

  memSelControl i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .fastRoute(fastRoute), .fastHit(fastHit), .coreHit(coreHit),
    .strobe(strobe)
  );

  memSelDatapath #(
    .ADDR_W(ADDR_W), .MOD_BITS(MOD_BITS), .FAST_WORDS(FAST_WORDS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqFastSel(reqFastSel), .reqAddr(reqAddr),
    .fastPresent(fastPresent), .fastAck(fastAck),
    .corePresent(corePresent), .coreAck(coreAck),
    .fastRoute(fastRoute), .fastHit(fastHit), .coreHit(coreHit),
    .fastEn(fastEn), .coreEn(coreEn), .nxmFlag(nxmFlag)
  );
endmodule

// File: rtl/memSelChecker.sv
module memSelChecker #(
  parameter int ADDR_W     = 18,
  parameter int MOD_BITS   = 4,
  parameter int FAST_WORDS = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     fastAck,
  input logic [(1<<MOD_BITS)-1:0] coreAck,
  input logic                     fastEn,
  input logic [(1<<MOD_BITS)-1:0] coreEn,
  input logic                     nxmFlag
);
  assert_onehot_enables_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fastEn, coreEn}));

  assert_fast_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    fastEn |=> !fastEn);

  assert_fast_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fastEn && fastAck) |=> (coreEn == '0) && !nxmFlag);

  assert_fast_fallback_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fastEn && !fastAck) |=> !fastEn && !nxmFlag);

  assert_core_noack_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((coreEn != '0) && ((coreEn & coreAck) == '0)) |=> nxmFlag);

  assert_core_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((coreEn & coreAck) != '0) |=> !nxmFlag);

  assert_nxm_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    nxmFlag |=> !nxmFlag);
endmodule

bind memSelDecoder memSelChecker #(
  .ADDR_W(ADDR_W), .MOD_BITS(MOD_BITS), .FAST_WORDS(FAST_WORDS)
) i_checker (
  .clk(clk), .rstN(rstN), .fastAck(fastAck), .coreAck(coreAck),
  .fastEn(fastEn), .coreEn(coreEn), .nxmFlag(nxmFlag)
);

// File: tb/test_memSelDecoder.sv
module test_memSelDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqFastSel = 1'b0;
  logic [17:0] reqAddr = '0;
  logic        fastPresent = 1'b0;
  logic        fastAck = 1'b0;
  logic [15:0] corePresent = '0;
  logic [15:0] coreAck = '0;
  logic        fastEn;
  logic [15:0] coreEn;
  logic        nxmFlag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  memSelDecoder i_memSelDecoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFastSel(reqFastSel),
    .reqAddr(reqAddr), .fastPresent(fastPresent), .fastAck(fastAck),
    .corePresent(corePresent), .coreAck(coreAck),
    .fastEn(fastEn), .coreEn(coreEn), .nxmFlag(nxmFlag)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One request; busy=1 keeps reqValid high with other inputs during the cycle (R10)
  task automatic runReq(input logic sel, input logic [17:0] addr, input logic fp,
                        input logic fr, input logic [15:0] pres, input logic [15:0] resp,
                        input logic busy);
    logic fastTry, hit;
    int   mod;
    mod     = int'(addr[17:14]);
    fastTry = sel && (addr < 18'd16) && fp;
    hit     = pres[mod] && resp[mod];
    reqFastSel = sel; reqAddr = addr; fastPresent = fp; fastAck = fr;
    corePresent = pres; coreAck = resp; reqValid = 1'b1;
    step();
    if (busy) begin
      reqFastSel = ~sel; reqAddr = addr ^ 18'h2c000; reqValid = 1'b1;
    end else reqValid = 1'b0;
    if (fastTry) begin
      check("R2 fastEn", {17'd0, fastEn}, 18'd1);
      check("R2 coreEn idle", {2'd0, coreEn}, 18'd0);
      if (fr) begin
        step();
        reqValid = 1'b0;
        check("R3 no core", {2'd0, coreEn}, 18'd0);
        check("R3 no fast", {17'd0, fastEn}, 18'd0);
        check("R3 no nxm", {17'd0, nxmFlag}, 18'd0);
        return;
      end
      step();
      check("R4 fallback fast low", {17'd0, fastEn}, 18'd0);
    end else begin
      check("R6 direct core fast low", {17'd0, fastEn}, 18'd0);
    end
    if (pres[mod]) check("R5 coreEn", {2'd0, coreEn}, {2'd0, 16'd1 << mod});
    else           check("R7 absent no enable", {2'd0, coreEn}, 18'd0);
    step();
    reqValid = 1'b0;
    if (!pres[mod])     check("R7 nxm", {17'd0, nxmFlag}, 18'd1);
    else if (!resp[mod]) check("R8 nxm", {17'd0, nxmFlag}, 18'd1);
    else                check("R9 no nxm", {17'd0, nxmFlag}, 18'd0);
    check("R10 enables idle", {1'b0, fastEn, coreEn}, 18'd0);
    step();
    check("R9 nxm pulse ends", {17'd0, nxmFlag}, 18'd0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset fastEn", {17'd0, fastEn}, 18'd0);
    check("R1 reset coreEn", {2'd0, coreEn}, 18'd0);
    check("R1 reset nxm", {17'd0, nxmFlag}, 18'd0);
    rstN = 1'b1;
    step();

    // Fast window edges and fast paths
    runReq(1'b1, 18'd15, 1'b1, 1'b1, 16'hffff, 16'hffff, 1'b0); // R3
    runReq(1'b1, 18'd0,  1'b1, 1'b0, 16'hffff, 16'hffff, 1'b0); // R4
    runReq(1'b1, 18'd16, 1'b1, 1'b1, 16'hffff, 16'hffff, 1'b0); // R6 edge
    runReq(1'b1, 18'd3,  1'b0, 1'b1, 16'h0001, 16'h0000, 1'b0); // R6 absent, R8
    runReq(1'b0, 18'd7,  1'b1, 1'b1, 16'h0000, 16'hffff, 1'b0); // R6, R7
    runReq(1'b1, 18'd2,  1'b1, 1'b0, 16'h0001, 16'h0001, 1'b1); // R10 busy

    // Sweep all modules against flag mixes
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 8; v++) begin
        logic [13:0] low;
        logic [15:0] pres, resp;
        low  = v[1] ? 14'(v * 2) : (14'h3fff - 14'(v));
        pres = ((m + v) % 3 != 0) ? 16'hffff : ~(16'd1 << m);
        resp = ((m + v) % 4 != 1) ? 16'hffff : ~(16'd1 << m);
        runReq(v[0], {4'(m), low}, v[2], m[0] ^ v[0], pres, resp, v[2] & v[1]);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule